// File: doc/BRIEF.md
# I-Structure Memory Cell Controller

This block is the structure memory of a dataflow machine. It holds a small array of 16-bit words, and each word has its own presence state (EMPTY or FULL) and a separate allocation flag. Request tokens arrive one at a time through a valid/ready port. Each carries an opcode, a constant cell address, up to two data operands and an opaque return tag. The tag packs the destination processing element, the instruction offset and the input port. Result tokens leave through a second valid/ready port and carry that same tag, so the network can deliver them to the node that asked.

Reads follow single-assignment rules. A read of a FULL cell is answered at once. A read of an EMPTY cell is parked in a short deferred-read list, and it is answered when a later write fills that cell. Increment, decrement and compare-and-swap are performed inside the memory, each in a single cycle, so no other request can come between their read and their update. A write to a cell that is already FULL is rejected and raises a one-cycle error pulse.

Top module: `istruct_mem`

## Requirements
- R1: After reset, every cell is EMPTY, holds 0 and is unallocated, the deferred list is empty, `rsp_valid` and `wr_err` are low, and `req_ready` is high.
- R2: A read (opcode 0) of a FULL cell, addressed by `req_const_addr`, returns the stored word on `rsp_data` in the cycle after acceptance. `rsp_tag` equals the request's `req_tag`, which is passed through unchanged as {pe[1:0], offset[4:0], port}.
- R3: A write (opcode 1) with `req_has_const`=1 stores `req_left` at `req_const_addr`. With `req_has_const`=0 it stores `req_right` at the address in the low bits of `req_left`, and `req_const_addr` is ignored. Either form makes an EMPTY cell FULL and produces no response.
- R4: A write (opcode 1) to a FULL cell leaves the word unchanged, produces no response, and drives `wr_err` high for exactly the cycle after acceptance.
- R5: A clear (opcode 2) makes the addressed cell EMPTY without a response, so that a later write is accepted without error.
- R6: A read of an EMPTY cell produces no response and is held. When a write fills that cell, every held read for it is answered with the written word, one response per cycle, oldest first. Held reads for other cells stay held. No request is accepted while such answers are pending.
- R7: The deferred list holds DEFER_DEPTH reads. While it is full, `req_ready` is low for a read request and stays high for any other opcode.
- R8: Read-increment (opcode 5) and read-decrement (opcode 6) return the word before the update and store it plus or minus 1, modulo 2^16, in one atomic step. They act whatever the presence state is, and they leave that state unchanged.
- R9: Compare-and-swap (opcode 7) takes the expected word on `req_left` and the new word on `req_right`. It replaces the cell only when the cell equals the expected word, and it always returns the word as it was before.
- R10: Alloc (opcode 3) sets and free (opcode 4) clears the cell's allocation flag. Each returns the previous flag in bit 0 of `rsp_data`, with all other bits 0, and leaves the word and its presence untouched.
- R11: `rsp_valid`, `rsp_data` and `rsp_tag` hold steady until `rsp_ready` is sampled high. While a response waits unaccepted, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request token present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 3 | Opcode (0 read, 1 write, 2 clear, 3 alloc, 4 free, 5 read-inc, 6 read-dec, 7 compare-and-swap) |
| req_has_const | input | 1 | Write form: 1 takes the address from the constant, 0 from the left operand |
| req_const_addr | input | ADDR_W | Cell address from the instruction constant |
| req_left | input | DATA_W | Left operand |
| req_right | input | DATA_W | Right operand |
| req_tag | input | TAG_W | Return destination {pe, offset, port} |
| rsp_valid | output | 1 | Result token present |
| rsp_ready | input | 1 | Network takes the result token |
| rsp_data | output | DATA_W | Result word |
| rsp_tag | output | TAG_W | Return destination copied from the request |
| wr_err | output | 1 | One-cycle pulse: a write hit a FULL cell |

## Verification
The checker assumes that the network follows the handshake: it may assert `rsp_ready` at any time, and it watches `req_ready` before it counts a request as taken. It also assumes that `req_op` is valid whenever `req_valid` is high, because the read-blocking rule for a full deferred list depends on the opcode. The bench changes inputs only on falling edges and holds each request until it sees `req_ready`. It releases every held read with a matching write before it starts the next group of tests, so the list never fills except in the test that fills it on purpose.

// File: rtl/ismem_pkg.sv
// Shared opcode encoding for the I-structure memory.
// Assumes a 3-bit opcode field on the request port.
package ismem_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_CLEAR = 3'd2,
        OP_ALLOC = 3'd3,
        OP_FREE  = 3'd4,
        OP_RDINC = 3'd5,
        OP_RDDEC = 3'd6,
        OP_CAS   = 3'd7
    } op_e;
endpackage

// File: rtl/ismem_cells.sv
// Cell array: word, presence bit and allocation bit for each cell.
// Port A reads and updates the request's cell. Port B reads only, for
// answering held reads. All updates take effect on the clock edge.
module ismem_cells #(
    parameter int DATA_W = 16,
    parameter int CELLS  = 16,
    parameter int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_data,
    output logic              a_full,
    output logic              a_alloc,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_full_set,
    input  logic              a_full_clr,
    input  logic              a_alloc_set,
    input  logic              a_alloc_clr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_data
);
    logic [DATA_W-1:0] words [CELLS];
    logic [CELLS-1:0]  full_q;
    logic [CELLS-1:0]  alloc_q;

    // Combinational read of both ports.
    always_comb begin
        a_data  = words[a_addr];
        a_full  = full_q[a_addr];
        a_alloc = alloc_q[a_addr];
        b_data  = words[b_addr];
    end

    // Apply the update for the port A cell, or clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) words[i] <= '0;
            full_q  <= '0;
            alloc_q <= '0;
        end else begin
            if (a_we)        words[a_addr]   <= a_wdata;
            if (a_full_set)  full_q[a_addr]  <= 1'b1;
            if (a_full_clr)  full_q[a_addr]  <= 1'b0;
            if (a_alloc_set) alloc_q[a_addr] <= 1'b1;
            if (a_alloc_clr) alloc_q[a_addr] <= 1'b0;
        end
    end
endmodule

// File: rtl/ismem_defer.sv
// Deferred-read list. It is kept compact and in arrival order: entries
// 0..cnt-1 are live, and index 0 is the oldest. A fill marks every live
// entry for that address as fired. A pop removes the oldest fired entry
// and shifts the younger ones down. Assumes that push, fill and pop are
// never asserted in the same cycle.
module ismem_defer #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 4,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              fill,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              pop,
    output logic              any_fired,
    output logic              full,
    output logic [ADDR_W-1:0] head_addr,
    output logic [TAG_W-1:0]  head_tag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [TAG_W-1:0]  e_tag  [DEPTH];
    logic [DEPTH-1:0]  e_fire;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  head;

    // Find the oldest fired entry.
    always_comb begin
        any_fired = 1'b0;
        head      = '0;
        head_addr = '0;
        head_tag  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!any_fired && CNT_W'(i) < cnt && e_fire[i]) begin
                any_fired = 1'b1;
                head      = CNT_W'(i);
                head_addr = e_addr[i];
                head_tag  = e_tag[i];
            end
        end
        full = (cnt == CNT_W'(DEPTH));
    end

    // Append, mark fired, or remove the oldest fired entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            e_fire <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                e_addr[i] <= '0;
                e_tag[i]  <= '0;
            end
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == cnt) begin
                    e_addr[i] <= push_addr;
                    e_tag[i]  <= push_tag;
                    e_fire[i] <= 1'b0;
                end
            end
            cnt <= cnt + 1'b1;
        end else if (fill) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) < cnt && e_addr[i] == fill_addr) e_fire[i] <= 1'b1;
        end else if (pop) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) >= head) begin
                    if (i < DEPTH - 1) begin
                        e_addr[i] <= e_addr[(i + 1 < DEPTH) ? i + 1 : i];
                        e_tag[i]  <= e_tag[(i + 1 < DEPTH) ? i + 1 : i];
                        e_fire[i] <= e_fire[(i + 1 < DEPTH) ? i + 1 : i];
                    end else begin
                        e_fire[i] <= 1'b0;
                    end
                end
            end
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ismem_rsp.sv
// One-entry response register with a valid/ready output. `free` is
// high when a new response may be loaded on this edge.
module ismem_rsp #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              out_ready,
    output logic              free,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic [TAG_W-1:0]  tag
);
    // The slot is free when it is empty or is being drained this edge.
    always_comb free = !valid || out_ready;

    // Load a new token or retire the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            tag   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= ld_data;
            tag   <= ld_tag;
        end else if (out_ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/istruct_mem.sv
// I-structure memory top. It decodes one request per cycle and performs
// it completely in that cycle, which makes the atomic operations atomic.
// While fired held reads are pending, it answers them instead of taking
// requests. Assumes that req_op is valid whenever req_valid is high
// (req_ready depends on it).
module istruct_mem #(
    parameter int DATA_W      = 16,
    parameter int CELLS       = 16,
    parameter int DEFER_DEPTH = 4,
    parameter int TAG_W       = 8,
    parameter int ADDR_W      = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic              req_has_const,
    input  logic [ADDR_W-1:0] req_const_addr,
    input  logic [DATA_W-1:0] req_left,
    input  logic [DATA_W-1:0] req_right,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              wr_err
);
    import ismem_pkg::*;

    op_e               op;
    logic              accept, two_op_wr, out_free;
    logic [ADDR_W-1:0] cell_addr;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] a_data, b_data, a_wdata;
    logic              a_full, a_alloc;
    logic              a_we, a_full_set, a_full_clr, a_alloc_set, a_alloc_clr;
    logic              dfr_push, dfr_fill, dfr_pop, dfr_fired, dfr_full;
    logic [ADDR_W-1:0] dfr_head_addr;
    logic [TAG_W-1:0]  dfr_head_tag;
    logic              ld;
    logic [DATA_W-1:0] ld_data;
    logic [TAG_W-1:0]  ld_tag;
    logic              err_now;

    // Accept gating and selection of the operand form.
    always_comb begin
        op        = op_e'(req_op);
        req_ready = out_free && !dfr_fired && !(dfr_full && op == OP_READ);
        accept    = req_valid && req_ready;
        two_op_wr = (op == OP_WRITE) && !req_has_const;
        cell_addr = two_op_wr ? req_left[ADDR_W-1:0] : req_const_addr;
        wr_word   = two_op_wr ? req_right : req_left;
    end

    // Decode the accepted request, or answer one fired held read.
    always_comb begin
        a_we = 1'b0; a_wdata = a_data;
        a_full_set = 1'b0; a_full_clr = 1'b0;
        a_alloc_set = 1'b0; a_alloc_clr = 1'b0;
        dfr_push = 1'b0; dfr_fill = 1'b0; dfr_pop = 1'b0;
        ld = 1'b0; ld_data = a_data; ld_tag = req_tag;
        err_now = 1'b0;
        if (accept) begin
            unique case (op)
                OP_READ: begin
                    if (a_full) ld = 1'b1;
                    else        dfr_push = 1'b1;
                end
                OP_WRITE: begin
                    if (a_full) err_now = 1'b1;
                    else begin
                        a_we = 1'b1; a_wdata = wr_word;
                        a_full_set = 1'b1; dfr_fill = 1'b1;
                    end
                end
                OP_CLEAR: a_full_clr = 1'b1;
                OP_ALLOC, OP_FREE: begin
                    a_alloc_set = (op == OP_ALLOC);
                    a_alloc_clr = (op == OP_FREE);
                    ld = 1'b1;
                    ld_data = {{(DATA_W-1){1'b0}}, a_alloc};
                end
                OP_RDINC, OP_RDDEC: begin
                    a_we = 1'b1; ld = 1'b1;
                    a_wdata = (op == OP_RDINC) ? a_data + 1'b1 : a_data - 1'b1;
                end
                OP_CAS: begin
                    ld = 1'b1;
                    if (a_data == req_left) begin
                        a_we = 1'b1; a_wdata = req_right;
                    end
                end
                default: ;
            endcase
        end else if (dfr_fired && out_free) begin
            dfr_pop = 1'b1;
            ld      = 1'b1;
            ld_data = b_data;
            ld_tag  = dfr_head_tag;
        end
    end

    // Register the error pulse for a write to a FULL cell.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= err_now;
    end

    ismem_cells #(.DATA_W(DATA_W), .CELLS(CELLS), .ADDR_W(ADDR_W)) u_cells (
        .clk(clk), .rst_n(rst_n),
        .a_addr(cell_addr), .a_data(a_data), .a_full(a_full), .a_alloc(a_alloc),
        .a_we(a_we), .a_wdata(a_wdata),
        .a_full_set(a_full_set), .a_full_clr(a_full_clr),
        .a_alloc_set(a_alloc_set), .a_alloc_clr(a_alloc_clr),
        .b_addr(dfr_head_addr), .b_data(b_data)
    );

    ismem_defer #(.DEPTH(DEFER_DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_defer (
        .clk(clk), .rst_n(rst_n),
        .push(dfr_push), .push_addr(cell_addr), .push_tag(req_tag),
        .fill(dfr_fill), .fill_addr(cell_addr), .pop(dfr_pop),
        .any_fired(dfr_fired), .full(dfr_full),
        .head_addr(dfr_head_addr), .head_tag(dfr_head_tag)
    );

    ismem_rsp #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .load(ld), .ld_data(ld_data), .ld_tag(ld_tag),
        .out_ready(rsp_ready), .free(out_free),
        .valid(rsp_valid), .data(rsp_data), .tag(rsp_tag)
    );
endmodule

// File: rtl/istruct_mem_chk.sv
// Protocol and ordering checks for istruct_mem, attached with bind.
// Assumes that req_op is valid whenever req_valid is high.
module istruct_mem_chk #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic              wr_err,
    input logic              drain_busy,
    input logic              list_full
);
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_tag)); // R11
    AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready); // R11
    AST_DRAIN_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        drain_busy |-> !req_ready); // R6
    AST_FULL_LIST_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        list_full && req_op == 3'd0 |-> !req_ready); // R7
    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(req_valid && req_ready && req_op == 3'd1)); // R4
    AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> !rsp_valid); // R4
endmodule

bind istruct_mem istruct_mem_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_tag(rsp_tag), .wr_err(wr_err),
    .drain_busy(dfr_fired), .list_full(dfr_full)
);

// File: tb/istruct_mem_test.sv
module istruct_mem_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic        req_has_const = 1'b1;
    logic [3:0]  req_const_addr = '0;
    logic [15:0] req_left = '0, req_right = '0;
    logic [7:0]  req_tag = '0;
    logic        rsp_valid, rsp_ready = 1'b1, wr_err;
    logic [15:0] rsp_data;
    logic [7:0]  rsp_tag;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic        got_v, got_e;
    logic [15:0] got_d;
    logic [7:0]  got_t;
    logic [15:0] c_data [8];
    logic [7:0]  c_tag  [8];
    int          c_n;

    always #2 clk = ~clk;

    istruct_mem uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_has_const(req_has_const), .req_const_addr(req_const_addr),
        .req_left(req_left), .req_right(req_right), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .wr_err(wr_err)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        hc;
        logic [3:0]  ca;
        logic [15:0] l;
        logic [15:0] r;
        logic [7:0]  tag;
        logic        ev;
        logic [15:0] ed;
        logic        ee;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{3'd1,1'b1,4'd3,16'h1234,16'h0000,8'h10,1'b0,16'h0000,1'b0,8'd3}, // R3 one-operand write
        '{3'd0,1'b1,4'd3,16'h0000,16'h0000,8'h21,1'b1,16'h1234,1'b0,8'd2}, // R2 read back
        '{3'd1,1'b0,4'd9,16'h0005,16'hBEEF,8'h11,1'b0,16'h0000,1'b0,8'd3}, // R3 two-operand write
        '{3'd0,1'b1,4'd5,16'h0000,16'h0000,8'h42,1'b1,16'hBEEF,1'b0,8'd3}, // R3 landed at cell 5
        '{3'd1,1'b1,4'd5,16'h1111,16'h0000,8'h12,1'b0,16'h0000,1'b1,8'd4}, // R4 write to FULL
        '{3'd0,1'b1,4'd5,16'h0000,16'h0000,8'h43,1'b1,16'hBEEF,1'b0,8'd4}, // R4 value kept
        '{3'd5,1'b1,4'd3,16'h0000,16'h0000,8'h51,1'b1,16'h1234,1'b0,8'd8}, // R8 inc returns old
        '{3'd0,1'b1,4'd3,16'h0000,16'h0000,8'h52,1'b1,16'h1235,1'b0,8'd8}, // R8 stored +1
        '{3'd6,1'b1,4'd7,16'h0000,16'h0000,8'h53,1'b1,16'h0000,1'b0,8'd8}, // R8 dec on EMPTY cell
        '{3'd6,1'b1,4'd7,16'h0000,16'h0000,8'h54,1'b1,16'hFFFF,1'b0,8'd8}, // R8 wrapped
        '{3'd5,1'b1,4'd7,16'h0000,16'h0000,8'h55,1'b1,16'hFFFE,1'b0,8'd8}, // R8
        '{3'd7,1'b1,4'd3,16'h9999,16'h0001,8'h61,1'b1,16'h1235,1'b0,8'd9}, // R9 mismatch
        '{3'd0,1'b1,4'd3,16'h0000,16'h0000,8'h62,1'b1,16'h1235,1'b0,8'd9}, // R9 unchanged
        '{3'd7,1'b1,4'd3,16'h1235,16'hABCD,8'h63,1'b1,16'h1235,1'b0,8'd9}, // R9 match
        '{3'd0,1'b1,4'd3,16'h0000,16'h0000,8'h64,1'b1,16'hABCD,1'b0,8'd9}, // R9 swapped
        '{3'd3,1'b1,4'd9,16'h0000,16'h0000,8'h71,1'b1,16'h0000,1'b0,8'd10}, // R10 alloc
        '{3'd3,1'b1,4'd9,16'h0000,16'h0000,8'h72,1'b1,16'h0001,1'b0,8'd10}, // R10
        '{3'd4,1'b1,4'd9,16'h0000,16'h0000,8'h73,1'b1,16'h0001,1'b0,8'd10}, // R10 free
        '{3'd4,1'b1,4'd9,16'h0000,16'h0000,8'h74,1'b1,16'h0000,1'b0,8'd10}, // R10
        '{3'd3,1'b1,4'd3,16'h0000,16'h0000,8'h75,1'b1,16'h0000,1'b0,8'd10}, // R10 alloc of data cell
        '{3'd0,1'b1,4'd3,16'h0000,16'h0000,8'h76,1'b1,16'hABCD,1'b0,8'd10}, // R10 data untouched
        '{3'd2,1'b1,4'd3,16'h0000,16'h0000,8'h81,1'b0,16'h0000,1'b0,8'd5}, // R5 clear
        '{3'd1,1'b1,4'd3,16'h0777,16'h0000,8'h82,1'b0,16'h0000,1'b0,8'd5}, // R5 write accepted
        '{3'd0,1'b1,4'd3,16'h0000,16'h0000,8'h83,1'b1,16'h0777,1'b0,8'd5}  // R5
    };

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Present one request, wait for acceptance, and sample the next cycle.
    task automatic do_req(input logic [2:0] op, input logic hc, input logic [3:0] ca,
                          input logic [15:0] l, input logic [15:0] r, input logic [7:0] tg);
        @(negedge clk);
        req_op = op; req_has_const = hc; req_const_addr = ca;
        req_left = l; req_right = r; req_tag = tg; req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        got_v = rsp_valid; got_d = rsp_data; got_t = rsp_tag; got_e = wr_err;
    endtask

    // Gather accepted responses over a number of cycles.
    task automatic collect(input int cycles);
        c_n = 0;
        for (int k = 0; k < cycles; k++) begin
            if (rsp_valid && rsp_ready && c_n < 8) begin
                c_data[c_n] = rsp_data;
                c_tag[c_n]  = rsp_tag;
                c_n++;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        check(wr_err == 1'b0, "R1", "wr_err after reset", 32'(wr_err), 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
        do_req(3'd0, 1'b1, 4'd0, 16'h0, 16'h0, 8'hA0);
        check(got_v == 1'b0, "R1", "read of reset cell held", 32'(got_v), 0);
        do_req(3'd1, 1'b1, 4'd0, 16'h0042, 16'h0, 8'hA1);
        collect(4);
        check(c_n == 1 && c_tag[0] == 8'hA0 && c_data[0] == 16'h0042, "R1",
              "held read on reset cell released", {c_n[7:0], c_tag[0], c_data[0]},
              {8'd1, 8'hA0, 16'h0042});

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i].op, VEC[i].hc, VEC[i].ca, VEC[i].l, VEC[i].r, VEC[i].tag);
            check(got_v == VEC[i].ev, $sformatf("R%0d", VEC[i].rq),
                  $sformatf("vector %0d rsp_valid", i), 32'(got_v), 32'(VEC[i].ev));
            if (VEC[i].ev)
                check(got_d == VEC[i].ed && got_t == VEC[i].tag, $sformatf("R%0d", VEC[i].rq),
                      $sformatf("vector %0d data/tag", i), {got_t, got_d}, {VEC[i].tag, VEC[i].ed});
            check(got_e == VEC[i].ee, $sformatf("R%0d", VEC[i].rq),
                  $sformatf("vector %0d wr_err", i), 32'(got_e), 32'(VEC[i].ee));
        end

        // R6: held reads released in arrival order, the other cell stays held.
        do_req(3'd0, 1'b1, 4'd12, 16'h0, 16'h0, 8'hC1);
        check(got_v == 1'b0, "R6", "read of EMPTY held", 32'(got_v), 0);
        do_req(3'd0, 1'b1, 4'd12, 16'h0, 16'h0, 8'hC2);
        do_req(3'd0, 1'b1, 4'd13, 16'h0, 16'h0, 8'hC3);
        do_req(3'd1, 1'b1, 4'd12, 16'h5A5A, 16'h0, 8'hC4);
        check(req_ready == 1'b0, "R6", "requests blocked while answering", 32'(req_ready), 0);
        collect(6);
        check(c_n == 2, "R6", "answer count for cell 12", 32'(c_n), 2);
        check(c_tag[0] == 8'hC1 && c_data[0] == 16'h5A5A, "R6", "first answer",
              {c_tag[0], c_data[0]}, {8'hC1, 16'h5A5A});
        check(c_tag[1] == 8'hC2 && c_data[1] == 16'h5A5A, "R6", "second answer",
              {c_tag[1], c_data[1]}, {8'hC2, 16'h5A5A});
        do_req(3'd1, 1'b1, 4'd13, 16'h3C3C, 16'h0, 8'hC5);
        collect(4);
        check(c_n == 1 && c_tag[0] == 8'hC3 && c_data[0] == 16'h3C3C, "R6",
              "cell 13 answer after its own write", {c_n[7:0], c_tag[0], c_data[0]},
              {8'd1, 8'hC3, 16'h3C3C});

        // R7: full list blocks reads only.
        for (int k = 0; k < 4; k++) do_req(3'd0, 1'b1, 4'd14, 16'h0, 16'h0, 8'(8'hE0 + k));
        @(negedge clk);
        req_op = 3'd0; req_const_addr = 4'd14; req_tag = 8'hEF; req_valid = 1'b1;
        #1;
        check(req_ready == 1'b0, "R7", "read refused when list full", 32'(req_ready), 0);
        req_op = 3'd1;
        #1;
        check(req_ready == 1'b1, "R7", "write still taken when list full", 32'(req_ready), 1);
        req_valid = 1'b0;
        do_req(3'd1, 1'b1, 4'd14, 16'h7E7E, 16'h0, 8'hE9);
        collect(8);
        check(c_n == 4, "R7", "answers after fill", 32'(c_n), 4);
        for (int k = 0; k < 4; k++)
            check(c_tag[k] == 8'(8'hE0 + k) && c_data[k] == 16'h7E7E, "R6",
                  "order of four held reads", {c_tag[k], c_data[k]}, {8'(8'hE0 + k), 16'h7E7E});

        // R11: response held under backpressure.
        rsp_ready = 1'b0;
        do_req(3'd0, 1'b1, 4'd5, 16'h0, 16'h0, 8'h99);
        check(got_v && got_d == 16'hBEEF && got_t == 8'h99, "R11", "response under stall",
              {got_t, got_d}, {8'h99, 16'hBEEF});
        req_op = 3'd0; req_const_addr = 4'd5; req_valid = 1'b1;
        #1;
        check(req_ready == 1'b0, "R11", "req_ready during stall", 32'(req_ready), 0);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_valid && rsp_data == 16'hBEEF && rsp_tag == 8'h99, "R11", "held response",
              {7'd0, rsp_valid, rsp_tag, rsp_data}, {8'd1, 8'h99, 16'hBEEF});
        rsp_ready = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11", "response retired", 32'(rsp_valid), 0);

        finish_run();
    end
endmodule